// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Sequencer

This block drives the four switch enables of a full bridge: high and low switch of leg 1, and high and low switch of leg 2. Each switching period is split into two halves. In each half, a power-transfer (active) interval across one bridge diagonal is followed by a freewheel (passive) interval. In that passive interval both high switches, or both low switches, conduct. The two halves use opposite diagonals and opposite freewheel pairs.

Every change of conduction pattern passes through a dead window. In that window, the switches about to change are off and only the switch common to both patterns stays on. The dead window before an active interval and the dead window after it are programmed independently, and a fixed minimum of `MIN_DT` clock cycles is always added. The active interval follows a duty command in clock cycles. The command saturates at the longest active time that still fits both dead windows in a half period. An all-ones command stands for an open loop and gives that maximum.

Period, duty and dead-time inputs are sampled once per half period, at its first cycle. A control loop can therefore update them at any time without tearing an interval.

Top module: `psfb_gate_seq`

## Requirements
- R1: While `rst_ni` is low, all four gate enables and `phase_o` are 0. On the first rising clock edge after release, the sequence begins with the lead-in dead window of half A (`phase_o` = 0).
- R2: Each half lasts floor(`period_i`/2) cycles. It runs a lead-in dead window of `MIN_DT`+`dead_pa_i` cycles, then the active interval, then a lead-out dead window of `MIN_DT`+`dead_ap_i` cycles, then the passive interval. `phase_o` is 0 in half A and 1 in half B, and the two halves alternate.
- R3: In half A the enables {ho1,ho2,lo1,lo2} are 0001 in the lead-in window, 1001 in the active interval, 1000 in the lead-out window and 1100 in the passive interval.
- R4: In half B the enables {ho1,ho2,lo1,lo2} are 0100 in the lead-in window, 0110 in the active interval, 0010 in the lead-out window and 0011 in the passive interval.
- R5: The active interval lasts min(`duty_i`, half − lead-in − lead-out) cycles. An all-ones `duty_i` (open loop) gives that maximum.
- R6: With `duty_i` = 0 there is no active interval: the lead-out window immediately follows the lead-in window.
- R7: When the active interval is at its maximum, the passive interval is empty. The next half's lead-in window immediately follows the lead-out window.
- R8: Changes on `period_i`, `duty_i`, `dead_pa_i` and `dead_ap_i` made inside a half have no effect on that half. Only the values present at the first cycle of a half are used.
- R9: ho1 and lo1 are never on together, and ho2 and lo2 are never on together.
- R10: A gate enable rises only if its same-leg partner was off in the previous cycle.
- R11: With both programmed dead times at 0, each dead window still lasts `MIN_DT` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Switching period in cycles |
| duty_i | input | CNT_W | Active interval length request in cycles |
| dead_pa_i | input | DT_W | Extra cycles in the dead window before the active interval |
| dead_ap_i | input | DT_W | Extra cycles in the dead window after the active interval |
| ho1_o | output | 1 | Leg 1 high switch enable |
| ho2_o | output | 1 | Leg 2 high switch enable |
| lo1_o | output | 1 | Leg 1 low switch enable |
| lo2_o | output | 1 | Leg 2 low switch enable |
| phase_o | output | 1 | Current half: 0 = A, 1 = B |

## Verification
The assertions assume that floor(`period_i`/2) is at least the sum of both dead windows. They also assume that `DT_W` is below `CNT_W`, so the window sums never wrap. Under those conditions the state order and the leg rules hold for any duty value. Every stimulus set keeps the half period at or above that sum, including the case where the passive interval comes out exactly empty. Inputs are always sampled at a half boundary, so the stimulus may change them at any time. One set deliberately changes them in the middle of a half and restores them before the next boundary.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEAD_PA,
    ST_ACTIVE,
    ST_DEAD_AP,
    ST_PASSIVE
  } seq_state_e;

  typedef struct packed {
    logic ho1;
    logic ho2;
    logic lo1;
    logic lo2;
  } gate_t;
endpackage

// File: rtl/psfb_interval_calc.sv
module psfb_interval_calc #(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int MIN_DT = 3
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_pa_i,
  input  logic [DT_W-1:0]  dead_ap_i,
  output logic [CNT_W-1:0] len_pa_o,
  output logic [CNT_W-1:0] len_act_o,
  output logic [CNT_W-1:0] len_ap_o,
  output logic [CNT_W-1:0] len_pas_o
);
  logic [CNT_W-1:0] half, dsum, max_act, act;
  logic             fits;

  always_comb begin
    half      = period_i >> 1;
    len_pa_o  = CNT_W'(MIN_DT) + CNT_W'(dead_pa_i);
    len_ap_o  = CNT_W'(MIN_DT) + CNT_W'(dead_ap_i);
    dsum      = len_pa_o + len_ap_o;
    fits      = half > dsum;
    max_act   = fits ? half - dsum : '0;
    act       = (duty_i < max_act) ? duty_i : max_act;
    len_act_o = act;
    len_pas_o = fits ? half - dsum - act : '0;
  end
endmodule

// File: rtl/psfb_seq_fsm.sv
module psfb_seq_fsm
  import psfb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] len_pa_i,
  input  logic [CNT_W-1:0] len_act_i,
  input  logic [CNT_W-1:0] len_ap_i,
  input  logic [CNT_W-1:0] len_pas_i,
  output seq_state_e       state_o,
  output logic             phase_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       state_q, state_d;
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lat_act_q, lat_ap_q, lat_pas_q;
  logic             latch;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q - ONE;
    latch   = 1'b0;
    if (state_q == ST_IDLE) begin
      latch   = 1'b1;
      state_d = ST_DEAD_PA;
      phase_d = 1'b0;
      cnt_d   = len_pa_i - ONE;
    end else if (cnt_q == '0) begin
      unique case (state_q)
        ST_DEAD_PA: begin
          if (lat_act_q != '0) begin
            state_d = ST_ACTIVE;
            cnt_d   = lat_act_q - ONE;
          end else begin
            state_d = ST_DEAD_AP;
            cnt_d   = lat_ap_q - ONE;
          end
        end
        ST_ACTIVE: begin
          state_d = ST_DEAD_AP;
          cnt_d   = lat_ap_q - ONE;
        end
        ST_DEAD_AP: begin
          if (lat_pas_q != '0) begin
            state_d = ST_PASSIVE;
            cnt_d   = lat_pas_q - ONE;
          end else begin
            latch   = 1'b1;
            state_d = ST_DEAD_PA;
            phase_d = ~phase_q;
            cnt_d   = len_pa_i - ONE;
          end
        end
        default: begin
          latch   = 1'b1;
          state_d = ST_DEAD_PA;
          phase_d = ~phase_q;
          cnt_d   = len_pa_i - ONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= 1'b0;
      cnt_q     <= '0;
      lat_act_q <= '0;
      lat_ap_q  <= '0;
      lat_pas_q <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (latch) begin
        lat_act_q <= len_act_i;
        lat_ap_q  <= len_ap_i;
        lat_pas_q <= len_pas_i;
      end
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;

  // R2
  state_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |->
      ((state_q == ST_ACTIVE  && $past(state_q) == ST_DEAD_PA) ||
       (state_q == ST_DEAD_AP && ($past(state_q) == ST_ACTIVE || $past(state_q) == ST_DEAD_PA)) ||
       (state_q == ST_PASSIVE && $past(state_q) == ST_DEAD_AP) ||
       (state_q == ST_DEAD_PA && $past(state_q) != ST_ACTIVE && $past(state_q) != ST_DEAD_PA)));

  // R2
  phase_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> (state_q == ST_DEAD_PA));
endmodule

// File: rtl/psfb_gate_decode.sv
module psfb_gate_decode
  import psfb_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       phase_i,
  output gate_t      gate_o
);
  always_comb begin
    gate_o = '0;
    unique case (state_i)
      ST_DEAD_PA: if (!phase_i) gate_o.lo2 = 1'b1;
                  else          gate_o.ho2 = 1'b1;
      ST_ACTIVE:  if (!phase_i) begin gate_o.ho1 = 1'b1; gate_o.lo2 = 1'b1; end
                  else          begin gate_o.ho2 = 1'b1; gate_o.lo1 = 1'b1; end
      ST_DEAD_AP: if (!phase_i) gate_o.ho1 = 1'b1;
                  else          gate_o.lo1 = 1'b1;
      ST_PASSIVE: if (!phase_i) begin gate_o.ho1 = 1'b1; gate_o.ho2 = 1'b1; end
                  else          begin gate_o.lo1 = 1'b1; gate_o.lo2 = 1'b1; end
      default:    gate_o = '0;
    endcase
  end
endmodule

// File: rtl/psfb_gate_seq.sv
module psfb_gate_seq
  import psfb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int MIN_DT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_pa_i,
  input  logic [DT_W-1:0]  dead_ap_i,
  output logic             ho1_o,
  output logic             ho2_o,
  output logic             lo1_o,
  output logic             lo2_o,
  output logic             phase_o
);
  logic [CNT_W-1:0] len_pa, len_act, len_ap, len_pas;
  seq_state_e       state;
  gate_t            gate;

  psfb_interval_calc #(
    .CNT_W (CNT_W),
    .DT_W  (DT_W),
    .MIN_DT(MIN_DT)
  ) u_calc (
    .period_i (period_i),
    .duty_i   (duty_i),
    .dead_pa_i(dead_pa_i),
    .dead_ap_i(dead_ap_i),
    .len_pa_o (len_pa),
    .len_act_o(len_act),
    .len_ap_o (len_ap),
    .len_pas_o(len_pas)
  );

  psfb_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .len_pa_i (len_pa),
    .len_act_i(len_act),
    .len_ap_i (len_ap),
    .len_pas_i(len_pas),
    .state_o  (state),
    .phase_o  (phase_o)
  );

  psfb_gate_decode u_dec (
    .state_i(state),
    .phase_i(phase_o),
    .gate_o (gate)
  );

  assign ho1_o = gate.ho1;
  assign ho2_o = gate.ho2;
  assign lo1_o = gate.lo1;
  assign lo2_o = gate.lo2;

  // R9
  leg1_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(ho1_o && lo1_o));
  // R9
  leg2_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(ho2_o && lo2_o));
  // R10
  ho1_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(ho1_o) |-> !$past(lo1_o));
  // R10
  lo1_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(lo1_o) |-> !$past(ho1_o));
  // R10
  ho2_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(ho2_o) |-> !$past(lo2_o));
  // R10
  lo2_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(lo2_o) |-> !$past(ho2_o));
endmodule

// File: tb/psfb_gate_seq_test.sv
module psfb_gate_seq_test;
  localparam int CNT_W  = 16;
  localparam int DT_W   = 8;
  localparam int MIN_DT = 3;

  typedef struct {
    logic [4:0] v;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] period = '0;
  logic [CNT_W-1:0] duty = '0;
  logic [DT_W-1:0]  dpa = '0;
  logic [DT_W-1:0]  dap = '0;
  logic             ho1, ho2, lo1, lo2, ph;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  bit   finished = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  psfb_gate_seq #(.CNT_W(CNT_W), .DT_W(DT_W), .MIN_DT(MIN_DT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .duty_i(duty),
    .dead_pa_i(dpa), .dead_ap_i(dap),
    .ho1_o(ho1), .ho2_o(ho2), .lo1_o(lo1), .lo2_o(lo2), .phase_o(ph)
  );

  task automatic push_n(input int n, input logic [4:0] v, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.v = v;
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  // expected outputs {phase,ho1,ho2,lo1,lo2} for two halves (R2..R7, R11)
  task automatic push_cfg(input int p, input int d, input int a, input int b,
                          input string tag, output int total);
    int half, tpa, tap, mx, act, pas;
    half = p / 2;
    tpa  = MIN_DT + a;
    tap  = MIN_DT + b;
    mx   = (half > tpa + tap) ? half - tpa - tap : 0;
    act  = (d < mx) ? d : mx;
    pas  = half - tpa - tap - act;
    push_n(tpa, 5'b0_0001, {tag, "/R3"});
    push_n(act, 5'b0_1001, {tag, "/R3"});
    push_n(tap, 5'b0_1000, {tag, "/R3"});
    push_n(pas, 5'b0_1100, {tag, "/R3"});
    push_n(tpa, 5'b1_0100, {tag, "/R4"});
    push_n(act, 5'b1_0110, {tag, "/R4"});
    push_n(tap, 5'b1_0010, {tag, "/R4"});
    push_n(pas, 5'b1_0011, {tag, "/R4"});
    total = 2 * half;
  endtask

  task automatic run_cfg(input int p, input int d, input int a, input int b,
                         input string tag, input bit mid_change);
    int total;
    period = CNT_W'(p);
    duty   = CNT_W'(d);
    dpa    = DT_W'(a);
    dap    = DT_W'(b);
    push_cfg(p, d, a, b, tag, total);
    for (int i = 1; i <= total; i++) begin
      @(negedge clk);
      if (mid_change && i == 3) begin
        duty = CNT_W'(1);
        dpa  = DT_W'(9);
        period = CNT_W'(90);
      end
      if (mid_change && i == 10) begin
        duty = CNT_W'(d);
        dpa  = DT_W'(a);
        period = CNT_W'(p);
      end
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic [4:0] pv;
    logic [4:0] got;
    exp_t e;
    pv = '0;
    wait (rst_n);
    forever begin
      @(posedge clk);
      @(negedge clk);
      if (done) break;
      if (q.size() == 0) continue;
      e = q.pop_front();
      got = {ph, ho1, ho2, lo1, lo2};
      checks++;
      if (got !== e.v) begin
        errors++;
        $display("FAIL %s: got %b expected %b", e.tag, got, e.v);
      end
      checks++;
      if ((ho1 && lo1) || (ho2 && lo2)) begin
        errors++;
        $display("FAIL R9: got %b expected no leg overlap", got);
      end
      checks++;
      if ((got[3] && !pv[3] && pv[1]) || (got[1] && !pv[1] && pv[3]) ||
          (got[2] && !pv[2] && pv[0]) || (got[0] && !pv[0] && pv[2])) begin
        errors++;
        $display("FAIL R10: got %b after %b expected partner off", got, pv);
      end
      pv = got;
    end
  end

  initial begin
    #3;
    checks++;
    if ({ph, ho1, ho2, lo1, lo2} !== 5'b0) begin
      errors++;
      $display("FAIL R1: got %b expected 00000", {ph, ho1, ho2, lo1, lo2});
    end
    period = CNT_W'(40);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_cfg(40, 5, 2, 1, "R2", 1'b0);
    run_cfg(40, 16'hFFFF, 0, 0, "R5", 1'b0);   // open loop, also R7 and R11
    run_cfg(30, 0, 1, 2, "R6", 1'b0);
    run_cfg(41, 8, 0, 0, "R8", 1'b1);          // odd period, mid-half changes
    run_cfg(50, 17, 1, 1, "R7", 1'b0);
    run_cfg(50, 18, 1, 1, "R5", 1'b0);
    @(negedge clk);
    done = 1'b1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: got %0d pending items expected 0", q.size());
    end
    rst_n = 1'b0;
    #1;
    checks++;
    if ({ph, ho1, ho2, lo1, lo2} !== 5'b0) begin
      errors++;
      $display("FAIL R1: got %b expected 00000 in reset", {ph, ho1, ho2, lo1, lo2});
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule